// File: doc/BRIEF.md
# Power-Fail Write-Protect Controller

This synchronous controller sits between an asynchronous, active-low host memory bus (chip select, output enable, write enable) and a memory array. It takes two digital supply flags from external comparators. One says the supply has dropped under the power-fail threshold. The other says the supply is below the level of the backup cell. From these flags the controller decides when host accesses reach the array, when writes are locked out, when the data bus must float, and when the backup cell feeds the array.

When the supply fails, a write that is already under way may finish, but only within a bounded number of cycles. Any other access is cut off at once. When the supply comes back, the controller keeps the array locked for a fixed recovery interval before it releases the bus. A latch that is set only once keeps the backup cell isolated until the supply has first been seen valid. All host and supply inputs pass through two-flop synchronizers before use, and every delay is a cycle count set by a parameter.

Top module: `pfwp_ctrl`

## Requirements
- R1: While reset is asserted and directly after it is released, `state_o` is 2 (protected), the link latch is clear, and every array strobe and the bus drive enable are low.
- R2: In normal operation (`state_o` = 0), with the synchronized inputs: chip select high gives no array select and no drive; chip select low with write high and output enable high selects the array without driving the bus; chip select low with write high and output enable low raises `arr_rd_o` and `dq_oe_o`.
- R3: In normal operation, chip select low together with write low raises `arr_wr_o` and never `dq_oe_o`, whatever the level of output enable.
- R4: In the protected (2) and recovering (3) states, every array strobe and the bus drive enable stay low for all levels of the three host inputs.
- R5: If the power-fail flag is seen while a write overlap is active, the state becomes draining (1) and `arr_wr_o` stays high until the overlap ends. The state then becomes protected. With no write overlap, the state goes straight from normal to protected.
- R6: A drain lasts at most `WPT_CYC` cycles. When a write is held past that limit, the state becomes protected 3 + `WPT_CYC` clock edges after the power-fail flag changes at the pin.
- R7: When the power-fail flag clears, the state passes through recovering and reaches normal exactly 3 + `REC_CYC` edges after the pin changes. If the flag returns during recovery, the state goes back to protected and the full interval starts again.
- R8: After reset, the full recovery interval is applied even if the power-fail flag is already clear.
- R9: If chip select falls in the same synchronized sample as write enable, or later, `dq_oe_o` stays low until chip select rises, even if write enable rises while chip select is still low.
- R10: `bkup_link_o` sets once the power-fail flag is seen clear and then stays set until reset. `bkup_sel_o` equals the link AND the synchronized low-supply flag, so the backup cell is never selected before the first valid supply.
- R11: During draining, `dq_oe_o` stays low and no new access reaches the array.
- R12: The state encoding on `state_o` is normal = 0, draining = 1, protected = 2, recovering = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| ce_n_i | input | 1 | Host chip select, active low, asynchronous |
| oe_n_i | input | 1 | Host output enable, active low, asynchronous |
| we_n_i | input | 1 | Host write enable, active low, asynchronous |
| pfail_i | input | 1 | High while the supply is below the power-fail threshold |
| vlow_i | input | 1 | High while the supply is below the backup-cell level |
| arr_sel_o | output | 1 | Array select |
| arr_wr_o | output | 1 | Array write strobe |
| arr_rd_o | output | 1 | Array read strobe |
| dq_oe_o | output | 1 | Drive enable for the host data bus |
| bkup_sel_o | output | 1 | Connect the backup cell to the array |
| bkup_link_o | output | 1 | Isolation of the backup cell has been removed |
| state_o | output | 2 | Controller state (encoding in R12) |

## Verification
The bench looks at the point where power fails in the middle of a write. A design that cut the write at once would drop `arr_wr_o` early. A design without the timeout would stay in draining for as long as the host holds the write. It also counts the exact recovery and drain intervals, edge by edge. An off-by-one counter, or a skipped recovery after reset, shows up as a wrong edge count. It runs the write-first ordering and then lets write enable rise under a held chip select. A controller without the high-impedance hold would then drive the bus. It also checks that the backup cell stays unselected before the first valid supply, which a latch with the wrong polarity would fail.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_PROT   = 2'd2,
    ST_RECOV  = 2'd3
  } pfwp_state_e;
endpackage

// File: rtl/pfwp_sync.sv
module pfwp_sync #(
  parameter int unsigned      WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/pfwp_seq.sv
module pfwp_seq
  import pfwp_pkg::*;
#(
  parameter int unsigned REC_CYC = 8000000,
  parameter int unsigned WPT_CYC = 10000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pf_s,
  input  logic        wr_ovl,
  output pfwp_state_e state_o,
  output logic        link_o
);
  localparam int unsigned MAXC  = (REC_CYC > WPT_CYC) ? REC_CYC : WPT_CYC;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] WPT_LAST = CNT_W'(WPT_CYC - 1);

  pfwp_state_e      st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;
  logic             link_q, link_en;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q + 1'b1;
    cnt_en = 1'b0;
    unique case (st_q)
      ST_PROT: begin
        if (!pf_s) begin
          st_n   = ST_RECOV;
          cnt_n  = '0;
          cnt_en = 1'b1;
        end
      end
      ST_RECOV: begin
        if (pf_s) st_n = ST_PROT;
        else if (cnt_q == REC_LAST) st_n = ST_NORMAL;
        else cnt_en = 1'b1;
      end
      ST_NORMAL: begin
        if (pf_s) begin
          if (wr_ovl) begin
            st_n   = ST_DRAIN;
            cnt_n  = '0;
            cnt_en = 1'b1;
          end else begin
            st_n = ST_PROT;
          end
        end
      end
      ST_DRAIN: begin
        if (!wr_ovl || cnt_q == WPT_LAST) st_n = ST_PROT;
        else cnt_en = 1'b1;
      end
      default: st_n = ST_PROT;
    endcase
  end

  assign link_en = !pf_s && !link_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PROT;
      cnt_q  <= REC_LAST;
      link_q <= 1'b0;
    end else begin
      st_q <= st_n;
      if (cnt_en)  cnt_q  <= cnt_n;
      if (link_en) link_q <= 1'b1;
    end
  end

  assign state_o = st_q;
  assign link_o  = link_q;
endmodule

// File: rtl/pfwp_decode.sv
module pfwp_decode
  import pfwp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  pfwp_state_e state_i,
  input  logic        ce_s,
  input  logic        oe_s,
  input  logic        we_s,
  output logic        wr_ovl_o,
  output logic        arr_sel_o,
  output logic        arr_wr_o,
  output logic        arr_rd_o,
  output logic        dq_oe_o
);
  logic acc_en, drn_en, sel, rd, ovl;
  logic ce_q, zh_q, zh_n, zh_en, z_set;

  assign acc_en = (state_i == ST_NORMAL);
  assign drn_en = (state_i == ST_DRAIN);
  assign sel    = !ce_s;
  assign ovl    = sel && !we_s;
  assign rd     = sel && we_s && !oe_s;

  // chip select falling while write enable is already (or just) low
  assign z_set = ce_q && !ce_s && !we_s;

  always_comb begin
    zh_n  = zh_q;
    zh_en = 1'b0;
    if (ce_s) begin
      zh_n  = 1'b0;
      zh_en = 1'b1;
    end else if (z_set) begin
      zh_n  = 1'b1;
      zh_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= 1'b1;
      zh_q <= 1'b0;
    end else begin
      ce_q <= ce_s;
      if (zh_en) zh_q <= zh_n;
    end
  end

  assign wr_ovl_o  = ovl;
  assign arr_sel_o = (acc_en && sel) || (drn_en && ovl);
  assign arr_wr_o  = (acc_en || drn_en) && ovl;
  assign arr_rd_o  = acc_en && rd;
  assign dq_oe_o   = acc_en && rd && !zh_q;
endmodule

// File: rtl/pfwp_ctrl.sv
module pfwp_ctrl
  import pfwp_pkg::*;
#(
  parameter int unsigned REC_CYC = 8000000,
  parameter int unsigned WPT_CYC = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n_i,
  input  logic       oe_n_i,
  input  logic       we_n_i,
  input  logic       pfail_i,
  input  logic       vlow_i,
  output logic       arr_sel_o,
  output logic       arr_wr_o,
  output logic       arr_rd_o,
  output logic       dq_oe_o,
  output logic       bkup_sel_o,
  output logic       bkup_link_o,
  output logic [1:0] state_o
);
  localparam int unsigned NSYNC = 5;

  logic [NSYNC-1:0] raw, syn;
  logic             ce_s, oe_s, we_s, pf_s, vl_s;
  logic             wr_ovl, link;
  pfwp_state_e      st;

  assign raw = {vlow_i, pfail_i, we_n_i, oe_n_i, ce_n_i};

  pfwp_sync #(.WIDTH(NSYNC), .RST_VAL({NSYNC{1'b1}})) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  assign {vl_s, pf_s, we_s, oe_s, ce_s} = syn;

  pfwp_seq #(.REC_CYC(REC_CYC), .WPT_CYC(WPT_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .pf_s(pf_s), .wr_ovl(wr_ovl),
    .state_o(st), .link_o(link)
  );

  pfwp_decode dec_i (
    .clk(clk), .rst_n(rst_n), .state_i(st),
    .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
    .wr_ovl_o(wr_ovl), .arr_sel_o(arr_sel_o), .arr_wr_o(arr_wr_o),
    .arr_rd_o(arr_rd_o), .dq_oe_o(dq_oe_o)
  );

  assign bkup_link_o = link;
  assign bkup_sel_o  = link && vl_s;
  assign state_o     = st;
endmodule

// File: rtl/pfwp_ctrl_chk.sv
module pfwp_ctrl_chk #(
  parameter int unsigned WPT_CYC = 10000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       arr_sel_o,
  input logic       arr_wr_o,
  input logic       arr_rd_o,
  input logic       dq_oe_o,
  input logic       bkup_sel_o,
  input logic       bkup_link_o,
  input logic [1:0] state_o
);
  int unsigned drain_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drain_cnt <= 0;
    else if (state_o == 2'd1) drain_cnt <= drain_cnt + 1;
    else drain_cnt <= 0;
  end

  assert_quiet_when_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_o[1] |-> !(arr_sel_o || arr_wr_o || arr_rd_o || dq_oe_o));

  assert_no_drive_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_o |-> !dq_oe_o);

  assert_drain_no_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1) |-> (!dq_oe_o && !arr_rd_o));

  assert_drain_from_normal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && $past(state_o) != 2'd1) |-> $past(state_o) == 2'd0);

  assert_no_skip_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |=> (state_o == 2'd2 || state_o == 2'd3));

  assert_drain_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drain_cnt <= WPT_CYC);

  assert_link_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bkup_link_o |=> bkup_link_o);

  assert_sel_needs_link_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bkup_sel_o |-> bkup_link_o);
endmodule

bind pfwp_ctrl pfwp_ctrl_chk #(.WPT_CYC(WPT_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .arr_sel_o(arr_sel_o), .arr_wr_o(arr_wr_o),
  .arr_rd_o(arr_rd_o), .dq_oe_o(dq_oe_o), .bkup_sel_o(bkup_sel_o),
  .bkup_link_o(bkup_link_o), .state_o(state_o)
);

// File: tb/pfwp_ctrl_tb_top.sv
`timescale 1ns/1ps
module pfwp_ctrl_tb_top;
  localparam int REC = 20;
  localparam int WPT = 8;

  logic clk, rst_n, ce_n, oe_n, we_n, pf, vl;
  logic arr_sel, arr_wr, arr_rd, dq_oe, bsel, blink;
  logic [1:0] st;
  int total, bad;
  bit done;

  pfwp_ctrl #(.REC_CYC(REC), .WPT_CYC(WPT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .pfail_i(pf), .vlow_i(vl), .arr_sel_o(arr_sel), .arr_wr_o(arr_wr),
    .arr_rd_o(arr_rd), .dq_oe_o(dq_oe), .bkup_sel_o(bsel),
    .bkup_link_o(blink), .state_o(st)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic outs_zero(input string tag);
    chk({tag, " arr_sel"}, int'(arr_sel), 0);
    chk({tag, " arr_wr"},  int'(arr_wr), 0);
    chk({tag, " arr_rd"},  int'(arr_rd), 0);
    chk({tag, " dq_oe"},   int'(dq_oe), 0);
  endtask

  task automatic wait_state(input int target, output int n);
    n = 0;
    while (int'(st) != target && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic bus_idle();
    ce_n = 1; oe_n = 1; we_n = 1;
    step(3);
  endtask

  task automatic recover(input string tag);
    int n;
    pf = 0;
    wait_state(0, n);
    chk({tag, " recovery edges"}, n, 3 + REC);
  endtask

  initial begin : watchdog
    int cyc;
    for (cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int n;
    bit last_wr;
    total = 0; bad = 0; done = 0;
    ce_n = 1; oe_n = 1; we_n = 1; pf = 1; vl = 1; rst_n = 0;
    step(3);
    // R1 during reset
    chk("R1 state in reset", int'(st), 2);
    outs_zero("R1 reset");
    chk("R1 link in reset", int'(blink), 0);
    rst_n = 1;
    chk("R1 state after release", int'(st), 2);
    step(5);
    // R10: isolated before first valid supply
    chk("R10 no backup before first supply", int'(bsel), 0);
    chk("R10 link clear", int'(blink), 0);
    // R4: sweep host inputs while protected
    for (int v = 0; v < 8; v++) begin
      {ce_n, oe_n, we_n} = 3'(v);
      step(3);
      outs_zero($sformatf("R4 protected combo %0d", v));
      chk("R12 protected code", int'(st), 2);
    end
    bus_idle();
    // R8 / R7: reset recovery with full interval
    vl = 0;
    recover("R8");
    chk("R10 link set", int'(blink), 1);
    chk("R10 backup off with supply high", int'(bsel), 0);
    // R2 / R3 sweep in normal state, CE applied last
    for (int v = 0; v < 8; v++) begin
      bit c, o, w;
      {c, o, w} = 3'(v);
      bus_idle();
      oe_n = o; we_n = w; step(3);
      ce_n = c; step(3);
      chk($sformatf("R2 sel c%0d o%0d w%0d", c, o, w), int'(arr_sel), int'(!c));
      chk($sformatf("R3 wr c%0d o%0d w%0d", c, o, w), int'(arr_wr), int'(!c && !w));
      chk($sformatf("R2 rd c%0d o%0d w%0d", c, o, w), int'(arr_rd), int'(!c && w && !o));
      chk($sformatf("R2 drive c%0d o%0d w%0d", c, o, w), int'(dq_oe), int'(!c && w && !o));
    end
    // R9: write enable low before chip select falls
    bus_idle();
    oe_n = 0; we_n = 0; step(3);
    ce_n = 0; step(3);
    chk("R9 write first strobe", int'(arr_wr), 1);
    we_n = 1; step(3);
    chk("R9 read decode present", int'(arr_rd), 1);
    chk("R9 bus held floating", int'(dq_oe), 0);
    ce_n = 1; step(3);
    ce_n = 0; step(3);
    chk("R9 drive after fresh select", int'(dq_oe), 1);
    // R9: same-sample fall of both
    bus_idle();
    oe_n = 0; ce_n = 0; we_n = 0; step(3);
    we_n = 1; step(3);
    chk("R9 simultaneous fall floats", int'(dq_oe), 0);
    // R9: chip select first, write later, drive returns
    bus_idle();
    oe_n = 0; ce_n = 0; step(3);
    chk("R2 read drive", int'(dq_oe), 1);
    we_n = 0; step(3);
    chk("R3 no drive in write", int'(dq_oe), 0);
    we_n = 1; step(3);
    chk("R9 select-first drives again", int'(dq_oe), 1);
    bus_idle();
    // R4: power fail with idle bus
    pf = 1; step(3);
    chk("R4 idle fail to protected", int'(st), 2);
    chk("R10 backup off while supply above cell", int'(bsel), 0);
    vl = 1; step(2);
    chk("R10 backup selected", int'(bsel), 1);
    chk("R10 link held", int'(blink), 1);
    vl = 0; step(2);
    chk("R10 backup released", int'(bsel), 0);
    // R7: abort recovery
    pf = 0; step(3 + 5);
    chk("R7 in recovery", int'(st), 3);
    outs_zero("R4 recovering");
    pf = 1; step(3);
    chk("R7 back to protected", int'(st), 2);
    recover("R7");
    // R5 / R11: drain that ends by the host
    oe_n = 0; ce_n = 0; we_n = 0; step(3);
    pf = 1; step(3);
    chk("R12 drain code", int'(st), 1);
    chk("R5 write continues", int'(arr_wr), 1);
    we_n = 1; step(2);
    chk("R11 still draining", int'(st), 1);
    chk("R11 read rejected", int'(dq_oe), 0);
    chk("R11 no array read", int'(arr_rd), 0);
    chk("R5 write ended", int'(arr_wr), 0);
    step(1);
    chk("R5 drain to protected", int'(st), 2);
    bus_idle();
    recover("R5");
    // R6: drain timeout
    ce_n = 0; we_n = 0; step(3);
    pf = 1;
    n = 0; last_wr = 0;
    while (int'(st) != 2 && n < 500) begin
      last_wr = arr_wr;
      @(negedge clk);
      n++;
    end
    chk("R6 timeout edges", n, 3 + WPT);
    chk("R6 write held until timeout", int'(last_wr), 1);
    outs_zero("R6 forced protect");
    bus_idle();
    recover("R6");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule